// File: doc/BRIEF.md
# Clock Output Pin Controller

This block decides what appears on a shared I/O pin that can bring the internal system clock off chip. It uses four inputs: a port direction bit, a clock-stop control bit, a bus-cycle-end strobe and an encoded processing state. From these it drives the pin high-impedance, holds it high, or gates the main clock or a slower subclock onto it. When the pin is not driven, the pin's input level is returned to the port logic.

The clock-stop bit is captured only when a bus cycle ends. A stop therefore never cuts a bus transfer short, and a request that is withdrawn before the strobe leaves no trace. Gating is arranged so that the pin never shows a shortened low pulse. A change between the main clock and the subclock always passes through a parked-high interval that covers at least one full subclock period.

State codes on `pstate`: 0 = active (high or medium speed), 1 = sleep or subsleep, 2 = subactive, 3 = software standby / watch / direct transition, 4 = hardware standby. Codes 5 to 7 are treated as hardware standby.

Top module: `clkout_pin_ctrl`

## Requirements
- R1: With `dir_out` = 0 the pin is not driven (`pad_oe` = 0) in every state, and `port_in` equals `pad_in`. While `pad_oe` = 1, `port_in` reads 0.
- R2: With `pstate` = 4 or any code from 5 to 7, `pad_oe` is 0 whatever `dir_out` and the stop bit hold.
- R3: With `dir_out` = 1, the captured stop bit 0 and `pstate` 0 or 1, `pad_out` follows `clk`: high while `clk` is high and low while it is low.
- R4: With `dir_out` = 1 and `pstate` = 3, `pad_oe` = 1 and `pad_out` is held at 1 whatever the stop bit holds.
- R5: `stop_req` is captured only on a cycle with `bus_end` = 1. A request raised and withdrawn between strobes has no effect. A captured 1 parks the pin high within three cycles. A captured 0 lets the clock out again.
- R6: With `dir_out` = 1, the captured stop bit 0 and `pstate` = 2, `pad_out` carries the subclock after a `SYNC_STAGES`-flop synchroniser and does not toggle with `clk`. A captured 1 holds the pin high.
- R7: The subclock gate opens and closes only while the synchronised subclock is high. The main-clock gate changes only on a rising `clk` edge. As a result, the first low pulse after a restart has full length.
- R8: A change from the main clock to the subclock, or the reverse, holds the pin high until `SW_EDGES` rising edges of the synchronised subclock have passed since the hold began. With the default of 2, this is at least one full subclock period.
- R9: Asynchronous reset (`rst_n` = 0) gives `pad_oe` = 0 and clears the captured stop bit. After reset the clock runs out without any `bus_end` strobe, even if `stop_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the clock gated onto the pin |
| sub_clk | input | 1 | Slow subclock, sampled through a synchroniser |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | Port direction bit, 1 = pin is an output |
| stop_req | input | 1 | Clock-stop control bit |
| bus_end | input | 1 | One-cycle strobe marking the end of a bus cycle |
| pstate | input | 3 | Encoded processing state |
| pad_in | input | 1 | Level present at the pin |
| pad_out | output | 1 | Value driven onto the pin |
| pad_oe | output | 1 | Pin output enable |
| port_in | output | 1 | Pin level returned to the port when not driven |

## Verification
The assertions assume that `dir_out`, `stop_req`, `bus_end` and `pstate` change only between rising `clk` edges. They also assume that `sub_clk` is much slower than `clk`, so each of its levels lasts several main-clock cycles after synchronisation. The stimulus meets both assumptions: every control input is driven on the falling edge of `clk`, and the subclock is generated in the bench as a square wave that toggles on a falling edge every fourth cycle. After each new input combination, the bench waits long enough for any hold interval to finish before it compares output counts.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  localparam int PSTATE_W = 3;

  // processing-state codes seen on pstate
  localparam logic [PSTATE_W-1:0] PS_ACTIVE = 3'd0;
  localparam logic [PSTATE_W-1:0] PS_SLEEP  = 3'd1;
  localparam logic [PSTATE_W-1:0] PS_SUBACT = 3'd2;
  localparam logic [PSTATE_W-1:0] PS_SWSTBY = 3'd3;
  localparam logic [PSTATE_W-1:0] PS_HWSTBY = 3'd4;

  // what the pin should carry
  typedef enum logic [1:0] {
    WANT_HIZ  = 2'd0,
    WANT_HIGH = 2'd1,
    WANT_MAIN = 2'd2,
    WANT_SUB  = 2'd3
  } want_e;

  // gating state of the output path
  typedef enum logic [1:0] {
    SRC_PARK = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_SUB  = 2'd2,
    SRC_HOLD = 2'd3
  } src_e;

  function automatic logic pin_drives(input logic dir, input logic [PSTATE_W-1:0] ps);
    return dir && (ps < PS_HWSTBY);
  endfunction

  function automatic want_e pick_want(input logic dir, input logic stop,
                                      input logic [PSTATE_W-1:0] ps);
    want_e w;
    if (!pin_drives(dir, ps)) begin
      w = WANT_HIZ;
    end else begin
      case (ps)
        PS_ACTIVE, PS_SLEEP: w = stop ? WANT_HIGH : WANT_MAIN;
        PS_SUBACT:           w = stop ? WANT_HIGH : WANT_SUB;
        default:             w = WANT_HIGH;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/clkout_sub_sync.sv
module clkout_sub_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_clk,
  output logic sub_lvl,
  output logic sub_rise
);

  logic [STAGES-1:0] shreg;
  logic              prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      prev_lvl <= 1'b0;
    end else begin
      shreg[0] <= sub_clk;
      for (int i = 1; i < STAGES; i++) shreg[i] <= shreg[i-1];
      prev_lvl <= shreg[STAGES-1];
    end
  end

  assign sub_lvl  = shreg[STAGES-1];
  assign sub_rise = shreg[STAGES-1] & ~prev_lvl;

endmodule

// File: rtl/clkout_stop_sampler.sv
module clkout_stop_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_end,
  input  logic stop_req,
  output logic stop_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stop_q <= 1'b0;
    else if (bus_end) stop_q <= stop_req;
  end

endmodule

// File: rtl/clkout_src_fsm.sv
module clkout_src_fsm
  import clkout_pkg::*;
#(
  parameter int SW_EDGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  want_e want,
  input  logic  sub_lvl,
  input  logic  sub_rise,
  output logic  run_main,
  output logic  run_sub,
  output logic  in_hold,
  output logic  hold_done
);

  localparam int CNT_W = $clog2(SW_EDGES + 1);

  src_e             cur, nxt;
  logic [CNT_W-1:0] edge_cnt;
  logic             last_sub;
  logic             last_valid;

  assign hold_done = (edge_cnt == CNT_W'(SW_EDGES));

  always_comb begin
    nxt = cur;
    case (cur)
      SRC_PARK: begin
        if (want == WANT_MAIN)
          nxt = (last_valid && last_sub) ? SRC_HOLD : SRC_MAIN;
        else if (want == WANT_SUB) begin
          if (last_valid && !last_sub) nxt = SRC_HOLD;
          else if (sub_lvl)            nxt = SRC_SUB;
        end
      end
      SRC_MAIN: if (want != WANT_MAIN) nxt = SRC_PARK;
      SRC_SUB:  if (want != WANT_SUB && sub_lvl) nxt = SRC_PARK;
      default: begin
        if (want != WANT_MAIN && want != WANT_SUB) nxt = SRC_PARK;
        else if (hold_done) begin
          if (want == WANT_MAIN)  nxt = SRC_MAIN;
          else if (sub_lvl)       nxt = SRC_SUB;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= SRC_PARK;
      edge_cnt   <= '0;
      last_sub   <= 1'b0;
      last_valid <= 1'b0;
    end else begin
      cur <= nxt;
      if (nxt == SRC_HOLD && cur != SRC_HOLD)
        edge_cnt <= '0;
      else if (cur == SRC_HOLD && sub_rise && !hold_done)
        edge_cnt <= edge_cnt + 1'b1;
      if (nxt == SRC_MAIN) begin
        last_valid <= 1'b1;
        last_sub   <= 1'b0;
      end else if (nxt == SRC_SUB) begin
        last_valid <= 1'b1;
        last_sub   <= 1'b1;
      end
    end
  end

  assign run_main = (cur == SRC_MAIN);
  assign run_sub  = (cur == SRC_SUB);
  assign in_hold  = (cur == SRC_HOLD);

endmodule

// File: rtl/clkout_pin_ctrl.sv
module clkout_pin_ctrl
  import clkout_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SW_EDGES    = 2
) (
  input  logic                clk,
  input  logic                sub_clk,
  input  logic                rst_n,
  input  logic                dir_out,
  input  logic                stop_req,
  input  logic                bus_end,
  input  logic [PSTATE_W-1:0] pstate,
  input  logic                pad_in,
  output logic                pad_out,
  output logic                pad_oe,
  output logic                port_in
);

  logic  sub_lvl, sub_rise;
  logic  stop_q;
  logic  run_main, run_sub, in_hold, hold_done;
  logic  drive_q;
  want_e want;

  clkout_sub_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sub_clk(sub_clk),
    .sub_lvl(sub_lvl), .sub_rise(sub_rise)
  );

  clkout_stop_sampler u_stop (
    .clk(clk), .rst_n(rst_n), .bus_end(bus_end),
    .stop_req(stop_req), .stop_q(stop_q)
  );

  assign want = pick_want(dir_out, stop_q, pstate);

  clkout_src_fsm #(.SW_EDGES(SW_EDGES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .want(want),
    .sub_lvl(sub_lvl), .sub_rise(sub_rise),
    .run_main(run_main), .run_sub(run_sub),
    .in_hold(in_hold), .hold_done(hold_done)
  );

  // output enable is registered so reset forces the pin to input mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= pin_drives(dir_out, pstate);
  end

  // OR-style gating: a disabled source leaves the pin parked high
  assign pad_out = run_main ? clk : (run_sub ? sub_lvl : 1'b1);
  assign pad_oe  = drive_q;
  assign port_in = drive_q ? 1'b0 : pad_in;

endmodule

// File: rtl/clkout_pin_ctrl_chk.sv
module clkout_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_out,
  input logic [2:0] pstate,
  input logic       bus_end,
  input logic       stop_q,
  input logic       pad_oe,
  input logic       run_main,
  input logic       run_sub,
  input logic       sub_lvl,
  input logic       in_hold,
  input logic       hold_done
);

  // R1
  dir_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_out |=> !pad_oe);

  // R2
  hw_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate >= 3'd4) |=> !pad_oe);

  // R4
  sw_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 3'd3) |=> !run_main);

  // R5
  stop_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_end |=> $stable(stop_q));

  // R5
  stop_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !run_main);

  // R7
  sub_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_sub) || $fell(run_sub)) |-> $past(sub_lvl));

  // R8
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !hold_done) |=> (!run_main && !run_sub));

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!pad_oe && !stop_q);
    end
  end

endmodule

bind clkout_pin_ctrl clkout_pin_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .pstate(pstate),
  .bus_end(bus_end), .stop_q(stop_q), .pad_oe(pad_oe),
  .run_main(run_main), .run_sub(run_sub), .sub_lvl(sub_lvl),
  .in_hold(in_hold), .hold_done(hold_done)
);

// File: tb/clkout_pin_ctrl_tb.sv
module clkout_pin_ctrl_tb;

  localparam int SUB_HALF = 4;   // subclock half period in clk cycles
  localparam int WIN      = 16;  // observation window in clk cycles

  logic       clk = 1'b0;
  logic       sub_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_out = 1'b0;
  logic       stop_req = 1'b0;
  logic       bus_end = 1'b0;
  logic [2:0] pstate = 3'd0;
  logic       pad_in = 1'b0;
  logic       pad_out, pad_oe, port_in;

  int checks = 0;
  int fails  = 0;
  int sub_cnt = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    sub_cnt = sub_cnt + 1;
    if (sub_cnt == SUB_HALF) begin
      sub_cnt = 0;
      sub_clk = ~sub_clk;
    end
  end

  clkout_pin_ctrl u_dut (
    .clk(clk), .sub_clk(sub_clk), .rst_n(rst_n), .dir_out(dir_out),
    .stop_req(stop_req), .bus_end(bus_end), .pstate(pstate),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .port_in(port_in)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_end();
    @(negedge clk); bus_end = 1'b1;
    @(negedge clk); bus_end = 1'b0;
  endtask

  // counts over n cycles, one sample in each clock phase
  task automatic observe(input int n, output int oe_n, output int hi1,
                         output int lo1, output int pin1);
    oe_n = 0; hi1 = 0; lo1 = 0; pin1 = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      oe_n += int'(pad_oe); hi1 += int'(pad_out); pin1 += int'(port_in);
      @(negedge clk); #2;
      oe_n += int'(pad_oe); lo1 += int'(pad_out); pin1 += int'(port_in);
    end
  endtask

  // length of the first high run seen in low-phase samples
  task automatic high_run(output int len);
    int guard = 0;
    len = 0;
    @(negedge clk); #2;
    while (pad_out == 1'b0 && guard < 12) begin
      @(negedge clk); #2; guard++;
    end
    while (pad_out == 1'b1 && len < 60) begin
      len++; @(negedge clk); #2;
    end
  endtask

  // length of the first low run seen in low-phase samples
  task automatic low_run(output int len);
    int guard = 0;
    len = 0;
    @(negedge clk); #2;
    while (pad_out == 1'b1 && guard < 30) begin
      @(negedge clk); #2; guard++;
    end
    while (pad_out == 1'b0 && len < 30) begin
      len++; @(negedge clk); #2;
    end
  endtask

  // expected class: 0 hiz, 1 high, 2 main clock, 3 subclock
  function automatic int exp_class(input bit d, input bit s, input int ps);
    if (ps >= 4 || !d) return 0;
    if (ps == 3 || s)  return 1;
    if (ps == 2)       return 3;
    return 2;
  endfunction

  function automatic string req_tag(input bit d, input int ps);
    if (ps >= 4) return "R2";
    if (!d)      return "R1";
    if (ps == 3) return "R4";
    if (ps == 2) return "R6";
    return "R3";
  endfunction

  initial begin
    int oe_n, hi1, lo1, pin1, cls, len;
    string tg;

    // R9: reset with an output configuration and a pending stop request
    dir_out = 1'b1; stop_req = 1'b1; pstate = 3'd0;
    cyc(3); #2;
    check(pad_oe == 1'b0, "R9 oe in reset", int'(pad_oe), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(10);
    observe(WIN, oe_n, hi1, lo1, pin1);
    check(oe_n == 2*WIN && hi1 == WIN && lo1 == 0, "R9 clock out after reset", lo1 + 100*hi1, 100*WIN);

    // R5: captured stop parks the pin; removal without a strobe is ignored
    strobe_end();
    cyc(3);
    observe(WIN, oe_n, hi1, lo1, pin1);
    check(lo1 == WIN && hi1 == WIN, "R5 parked high after strobe", lo1, WIN);
    @(negedge clk); stop_req = 1'b0;
    cyc(10);
    observe(WIN, oe_n, hi1, lo1, pin1);
    check(lo1 == WIN, "R5 clear without strobe ignored", lo1, WIN);
    strobe_end();
    cyc(3);
    observe(WIN, oe_n, hi1, lo1, pin1);
    check(lo1 == 0 && hi1 == WIN, "R5 clock resumes after strobe", lo1, 0);

    // R5: request withdrawn before the strobe
    @(negedge clk); stop_req = 1'b1;
    cyc(3);
    @(negedge clk); stop_req = 1'b0;
    strobe_end();
    cyc(3);
    observe(WIN, oe_n, hi1, lo1, pin1);
    check(lo1 == 0 && hi1 == WIN, "R5 withdrawn request", lo1, 0);

    // R8: main to subclock passes through a long high interval
    @(negedge clk); pstate = 3'd2;
    high_run(len);
    check(len >= 2*SUB_HALF && len < 60, "R8 main to sub hold", len, 2*SUB_HALF);
    cyc(40);
    observe(WIN, oe_n, hi1, lo1, pin1);
    check(hi1 == WIN/2 && lo1 == WIN/2, "R6 subclock on pin", lo1, WIN/2);

    // R7: restart of the subclock gives a full first low pulse
    @(negedge clk); stop_req = 1'b1;
    strobe_end();
    cyc(20);
    @(negedge clk); stop_req = 1'b0;
    strobe_end();
    low_run(len);
    check(len == SUB_HALF, "R7 full first low after restart", len, SUB_HALF);

    // R8: subclock to main clock
    cyc(20);
    @(negedge clk); pstate = 3'd0;
    high_run(len);
    check(len >= 2*SUB_HALF && len < 60, "R8 sub to main hold", len, 2*SUB_HALF);
    cyc(10);
    observe(WIN, oe_n, hi1, lo1, pin1);
    check(lo1 == 0 && hi1 == WIN, "R3 main clock after switch", lo1, 0);

    // sweep every direction, stop and state combination
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        for (int ps = 0; ps < 8; ps++) begin
          @(negedge clk);
          dir_out  = d[0];
          stop_req = s[0];
          pstate   = ps[2:0];
          pad_in   = ps[0] ^ s[0];
          strobe_end();
          cyc(40);
          observe(WIN, oe_n, hi1, lo1, pin1);
          cls = exp_class(d[0], s[0], ps);
          tg  = req_tag(d[0], ps);
          check(oe_n == ((cls == 0) ? 0 : 2*WIN), {tg, " oe count"}, oe_n, (cls == 0) ? 0 : 2*WIN);
          check(pin1 == ((cls == 0) ? 2*WIN*int'(pad_in) : 0), {tg, " R1 port_in count"}, pin1,
                (cls == 0) ? 2*WIN*int'(pad_in) : 0);
          if (cls == 1) check(hi1 == WIN && lo1 == WIN, {tg, " fixed high"}, lo1, WIN);
          if (cls == 2) check(hi1 == WIN && lo1 == 0, {tg, " main clock"}, lo1, 0);
          if (cls == 3) check(hi1 == WIN/2 && lo1 == WIN/2, {tg, " subclock"}, lo1, WIN/2);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule